// File: doc/BRIEF.md
# Bidirectional Port with Change Interrupt

This block is an 8-bit general-purpose I/O port that sits on a small CPU register bus. Each pin can be an input or an output, and each has its own direction bit. A data latch holds the values driven on output pins. A single global control turns on weak pull-ups, and only pins that are inputs receive them. The pin inputs are synchronized inside the block before they are used.

The upper four pins watch for change. Each upper pin that is an input is compared with a snapshot. The snapshot is taken whenever software reads or writes the data register. Any difference sets a sticky change flag. The flag is set again on every cycle while the difference lasts, so software must first access the data register and only then clear the flag.

Pin 0 also works as an external interrupt input, and a configuration bit chooses which edge is active. Each of the two flags is gated by its own enable bit to give a level interrupt request.

Register map. Offset 0 is DATA, offset 1 is DIR, offset 2 is CFG and offset 3 is IRQ.
- CFG bit 0 is `pu_dis`, which is active high and turns the pull-ups off.
- CFG bit 1 is `edge_rise`: 1 selects the rising edge and 0 selects the falling edge.
- IRQ bit 0 is the change flag and IRQ bit 1 is the external flag.
- IRQ bit 4 is the change enable and IRQ bit 5 is the external enable.
- Any bit not listed here reads as 0.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset:
  - DIR reads 0xFF (all pins inputs) and the data latch is 0x00.
  - CFG reads 0x03 (pull-ups off, rising edge).
  - IRQ reads 0x00.
  - `pin_oe`, `pin_pu`, `irq_chg` and `irq_ext` are all 0.
- R2: DIR reads back as written. `pin_oe[i]` is the inverse of DIR bit i (DIR bit = 1 means input). `pin_out` equals the value last written to DATA.
- R3: `pin_pu[i]` is 1 exactly when CFG bit 0 is 0 and DIR bit i is 1. An output pin never has its pull-up on.
- R4: A read of DATA returns the synchronized pin level for input pins and the latch value for output pins.
- R5: The change flag (IRQ bit 0) is set within 3 cycles of a change on an input pin in bits 7:4 that differs from the snapshot. Changes on bits 3:0, and changes on bits 7:4 that are outputs, never set the flag.
- R6: While a mismatch persists, writing 0 to IRQ bit 0 leaves the flag at 1.
- R7: A read or write of DATA refreshes the snapshot with the current synchronized pins. After that access, writing 0 to IRQ bit 0 clears the flag.
- R8: The external flag (IRQ bit 1) is set on a rising edge of pin 0 when CFG bit 1 = 1, and on a falling edge when CFG bit 1 = 0. The edge that is not selected is ignored.
- R9: Writing 0 to a flag bit of IRQ clears that flag. Writing 1 leaves it unchanged and never sets it.
- R10: `irq_chg` is the change flag ANDed with IRQ bit 4, and `irq_ext` is the external flag ANDed with IRQ bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of DATA refreshes the snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| irq_chg | output | 1 | Change interrupt request |
| irq_ext | output | 1 | External edge interrupt request |

## Verification
The hardest case to reach is a software clear that collides with a mismatch that is still present. To reach it, the bench holds an upper input pin away from its snapshot and writes 0 to the flag. It checks that the flag reads back 1. It then refreshes the snapshot in two ways, once with a DATA read and once with a DATA write, and checks that the same clear now takes effect. Masking is covered as well: an upper pin is first made an output and toggled without raising the flag, and then turned back into an input while its level still differs from the snapshot.

// File: rtl/gpio_chg_pkg.sv
// Shared register offsets and bit positions for the change-interrupt port.
package gpio_chg_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_CFG  = 2'd2,
        REG_IRQ  = 2'd3
    } reg_addr_e;

    localparam int unsigned CFG_PU_DIS_BIT    = 0;
    localparam int unsigned CFG_EDGE_RISE_BIT = 1;
    localparam int unsigned IRQ_CHG_FLAG_BIT  = 0;
    localparam int unsigned IRQ_EXT_FLAG_BIT  = 1;
    localparam int unsigned IRQ_CHG_EN_BIT    = 4;
    localparam int unsigned IRQ_EXT_EN_BIT    = 5;
endpackage

// File: rtl/gpio_chg_sync.sv
// Multi-stage synchronizer for the pin inputs.
// Assumes: STAGES >= 1; the output lags the input by STAGES clock edges.
module gpio_chg_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage samples the asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-registers the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_chg_regs.sv
// Register file and bus decode: data latch, direction, configuration and enables.
// Assumes: W >= 6 so that the configuration and IRQ bits fit in one bus word.
// Read data is combinational. Flag clears are sent to the flag owners as requests.
module gpio_chg_regs
    import gpio_chg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [W-1:0]          bus_wdata,
    output logic [W-1:0]          bus_rdata,
    input  logic [W-1:0]          pin_sync,
    input  logic                  chg_flag,
    input  logic                  ext_flag,
    output logic [W-1:0]          dir,
    output logic [W-1:0]          latch,
    output logic                  pu_dis,
    output logic                  edge_rise,
    output logic                  chg_en,
    output logic                  ext_en,
    output logic                  data_access,
    output logic                  chg_clr_req,
    output logic                  ext_clr_req
);
    logic wr_data, wr_dir, wr_cfg, wr_irq, rd_data;

    // Decode the strobes against the offset.
    always_comb begin
        wr_data = bus_wr && (bus_addr == REG_DATA);
        wr_dir  = bus_wr && (bus_addr == REG_DIR);
        wr_cfg  = bus_wr && (bus_addr == REG_CFG);
        wr_irq  = bus_wr && (bus_addr == REG_IRQ);
        rd_data = bus_rd && (bus_addr == REG_DATA);
    end

    assign data_access = wr_data || rd_data;
    assign chg_clr_req = wr_irq && !bus_wdata[IRQ_CHG_FLAG_BIT];
    assign ext_clr_req = wr_irq && !bus_wdata[IRQ_EXT_FLAG_BIT];

    // Output data latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch <= '0;
        else if (wr_data) latch <= bus_wdata;
    end

    // Direction register; all inputs after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir <= '1;
        else if (wr_dir) dir <= bus_wdata;
    end

    // Configuration: pull-ups off and rising edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_dis    <= 1'b1;
            edge_rise <= 1'b1;
        end else if (wr_cfg) begin
            pu_dis    <= bus_wdata[CFG_PU_DIS_BIT];
            edge_rise <= bus_wdata[CFG_EDGE_RISE_BIT];
        end
    end

    // Interrupt enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_en <= 1'b0;
            ext_en <= 1'b0;
        end else if (wr_irq) begin
            chg_en <= bus_wdata[IRQ_CHG_EN_BIT];
            ext_en <= bus_wdata[IRQ_EXT_EN_BIT];
        end
    end

    // Read mux: the data view merges the pins (inputs) with the latch (outputs).
    always_comb begin
        bus_rdata = '0;
        unique case (reg_addr_e'(bus_addr))
            REG_DATA: bus_rdata = (pin_sync & dir) | (latch & ~dir);
            REG_DIR:  bus_rdata = dir;
            REG_CFG: begin
                bus_rdata[CFG_PU_DIS_BIT]    = pu_dis;
                bus_rdata[CFG_EDGE_RISE_BIT] = edge_rise;
            end
            REG_IRQ: begin
                bus_rdata[IRQ_CHG_FLAG_BIT] = chg_flag;
                bus_rdata[IRQ_EXT_FLAG_BIT] = ext_flag;
                bus_rdata[IRQ_CHG_EN_BIT]   = chg_en;
                bus_rdata[IRQ_EXT_EN_BIT]   = ext_en;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_chg_detect.sv
// Change detector for the watched pins.
// It compares the synchronized input pins with a snapshot that is refreshed
// on every access to the data register. Any difference keeps setting the
// sticky flag, and setting takes priority over a software clear.
module gpio_chg_detect #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_sync,
    input  logic [N-1:0] is_input,
    input  logic         data_access,
    input  logic         clr_req,
    output logic [N-1:0] snap,
    output logic         mismatch,
    output logic         chg_flag
);
    logic [N-1:0] diff;

    // Per-pin difference, masked so that only input pins count.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign diff[i] = is_input[i] && (pin_sync[i] != snap[i]);
    end

    assign mismatch = |diff;

    // Snapshot taken on any data register access.
    always_ff @(posedge clk) begin
        if (!rst_n)           snap <= '0;
        else if (data_access) snap <= pin_sync;
    end

    // Sticky flag; a mismatch sets it again over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        chg_flag <= 1'b0;
        else if (mismatch) chg_flag <= 1'b1;
        else if (clr_req)  chg_flag <= 1'b0;
    end
endmodule

// File: rtl/gpio_chg_edge.sv
// Edge detector for the external interrupt pin.
// Assumes the input is already synchronized. rise_sel picks which edge sets the flag.
module gpio_chg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_bit,
    input  logic rise_sel,
    input  logic clr_req,
    output logic ext_set,
    output logic ext_flag
);
    logic prev;

    // Previous sample of the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin_bit;
    end

    assign ext_set = rise_sel ? (pin_bit && !prev) : (!pin_bit && prev);

    // Sticky flag; a new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext_flag <= 1'b0;
        else if (ext_set) ext_flag <= 1'b1;
        else if (clr_req) ext_flag <= 1'b0;
    end
endmodule

// File: rtl/gpio_chg_port.sv
// Top of the bidirectional port: synchronizer, registers, change detector and
// external edge detector. The pads provide pin_in; this block drives the
// per-pin enables.
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned CHG_LO      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned EXT_BIT     = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [PORT_W-1:0]     bus_wdata,
    output logic [PORT_W-1:0]     bus_rdata,
    input  logic [PORT_W-1:0]     pin_in,
    output logic [PORT_W-1:0]     pin_oe,
    output logic [PORT_W-1:0]     pin_out,
    output logic [PORT_W-1:0]     pin_pu,
    output logic                  irq_chg,
    output logic                  irq_ext
);
    localparam int unsigned CHG_N = PORT_W - CHG_LO;

    logic [PORT_W-1:0] pin_sync, dir, latch;
    logic [CHG_N-1:0]  chg_sync, snap;
    logic pu_dis, edge_rise, chg_en, ext_en;
    logic data_access, chg_clr_req, ext_clr_req;
    logic chg_flag, ext_flag, mismatch, ext_set;

    gpio_chg_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_chg_regs #(.W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_sync(pin_sync), .chg_flag(chg_flag), .ext_flag(ext_flag),
        .dir(dir), .latch(latch), .pu_dis(pu_dis), .edge_rise(edge_rise),
        .chg_en(chg_en), .ext_en(ext_en), .data_access(data_access),
        .chg_clr_req(chg_clr_req), .ext_clr_req(ext_clr_req)
    );

    assign chg_sync = pin_sync[PORT_W-1:CHG_LO];

    gpio_chg_detect #(.N(CHG_N)) u_det (
        .clk(clk), .rst_n(rst_n),
        .pin_sync(chg_sync), .is_input(dir[PORT_W-1:CHG_LO]),
        .data_access(data_access), .clr_req(chg_clr_req),
        .snap(snap), .mismatch(mismatch), .chg_flag(chg_flag)
    );

    gpio_chg_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .pin_bit(pin_sync[EXT_BIT]), .rise_sel(edge_rise),
        .clr_req(ext_clr_req), .ext_set(ext_set), .ext_flag(ext_flag)
    );

    // Pad controls: drive when the direction bit is 0; pull up only inputs.
    always_comb begin
        pin_oe  = ~dir;
        pin_out = latch;
        pin_pu  = dir & {PORT_W{~pu_dis}};
    end

    assign irq_chg = chg_flag && chg_en;
    assign irq_ext = ext_flag && ext_en;
endmodule

// File: rtl/gpio_chg_port_chk.sv
// Assertion checker bound to gpio_chg_port. It observes ports and the
// signals that pass between the sub-blocks.
module gpio_chg_port_chk #(
    parameter int unsigned PORT_W = 8,
    parameter int unsigned CHG_N  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_pu,
    input logic              irq_chg,
    input logic              irq_ext,
    input logic              chg_flag,
    input logic              ext_flag,
    input logic              mismatch,
    input logic              ext_set,
    input logic              ext_clr_req,
    input logic              data_access,
    input logic [CHG_N-1:0]  snap,
    input logic [CHG_N-1:0]  chg_sync
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0) && (pin_pu == '0) && !irq_chg && !irq_ext); // R1

    AST_PU_ONLY_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0); // R3

    AST_FLAG_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_flag) |-> $past(mismatch)); // R5

    AST_FLAG_HELD_BY_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && mismatch) |=> chg_flag); // R6

    AST_SNAP_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        data_access |=> (snap == $past(chg_sync))); // R7

    AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clr_req && !ext_set) |=> !ext_flag); // R9

    AST_IRQ_CHG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_chg |-> chg_flag); // R10

    AST_IRQ_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ext |-> ext_flag); // R10
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.PORT_W(PORT_W), .CHG_N(CHG_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .irq_chg(irq_chg), .irq_ext(irq_ext), .chg_flag(chg_flag),
    .ext_flag(ext_flag), .mismatch(mismatch), .ext_set(ext_set),
    .ext_clr_req(ext_clr_req), .data_access(data_access),
    .snap(snap), .chg_sync(chg_sync)
);

// File: tb/gpio_chg_port_tb.sv
// Directed bench for gpio_chg_port: one task per scenario, each checking its own results.
module gpio_chg_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out, pin_pu;
    logic       irq_chg, irq_ext;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [1:0] A_DATA = 2'd0, A_DIR = 2'd1, A_CFG = 2'd2, A_IRQ = 2'd3;

    always #4 clk = ~clk;

    gpio_chg_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .irq_chg(irq_chg), .irq_ext(irq_ext)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // Return to a known state: all inputs, pins low, snapshot fresh, flags clear.
    task automatic restore();
        logic [7:0] d;
        bus_write(A_DIR, 8'hFF);
        bus_write(A_CFG, 8'h03);
        pin_in = 8'h00;
        settle();
        bus_read(A_DATA, d);
        bus_write(A_IRQ, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_pu", pin_pu, 8'h00);
        check("R1 irq outputs", {6'b0, irq_ext, irq_chg}, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        bus_read(A_DIR, d); check("R1 DIR", d, 8'hFF);
        bus_read(A_CFG, d); check("R1 CFG", d, 8'h03);
        bus_read(A_IRQ, d); check("R1 IRQ", d, 8'h00);
    endtask

    task automatic t_direction();
        logic [7:0] d;
        bus_write(A_DIR, 8'hF0);
        bus_write(A_DATA, 8'hA5);
        check("R2 pin_oe", pin_oe, 8'h0F);
        check("R2 pin_out", pin_out, 8'hA5);
        bus_read(A_DIR, d); check("R2 DIR readback", d, 8'hF0);
        pin_in = 8'h3C;
        settle();
        bus_read(A_DATA, d); check("R4 merged data read", d, 8'h35);
        restore();
    endtask

    task automatic t_pullup();
        bus_write(A_CFG, 8'h02);
        bus_write(A_DIR, 8'hF0);
        check("R3 pull-ups inputs only", pin_pu, 8'hF0);
        bus_write(A_DIR, 8'hFF);
        check("R3 pull-ups all inputs", pin_pu, 8'hFF);
        bus_write(A_CFG, 8'h03);
        check("R3 pull-ups disabled", pin_pu, 8'h00);
        restore();
    endtask

    task automatic t_change();
        logic [7:0] d;
        pin_in = 8'h0F;
        settle();
        bus_read(A_IRQ, d); check("R5 low pins ignored", d & 8'h01, 8'h00);
        pin_in = 8'h1F;
        settle();
        bus_read(A_IRQ, d); check("R5 upper input change sets flag", d & 8'h01, 8'h01);
        check("R10 irq_chg masked when disabled", {7'b0, irq_chg}, 8'h00);
        bus_write(A_IRQ, 8'h10);
        bus_read(A_IRQ, d); check("R6 clear ignored during mismatch", d & 8'h01, 8'h01);
        check("R10 irq_chg asserted", {7'b0, irq_chg}, 8'h01);
        bus_read(A_DATA, d);
        bus_write(A_IRQ, 8'h10);
        bus_read(A_IRQ, d); check("R7 clear after data read", d & 8'h01, 8'h00);
        check("R10 irq_chg drops", {7'b0, irq_chg}, 8'h00);
        // Bit 7 as output: its toggle is masked.
        bus_write(A_DIR, 8'h7F);
        bus_write(A_IRQ, 8'h00);
        pin_in = 8'h9F;
        settle();
        bus_read(A_IRQ, d); check("R5 output pin masked", d & 8'h01, 8'h00);
        // Back to input while differing: mismatch, then refresh by a data write.
        bus_write(A_DIR, 8'hFF);
        settle();
        bus_write(A_IRQ, 8'h00);
        bus_read(A_IRQ, d); check("R6 flag held by mismatch", d & 8'h01, 8'h01);
        bus_write(A_DATA, 8'h00);
        bus_write(A_IRQ, 8'h00);
        bus_read(A_IRQ, d); check("R7 clear after data write", d & 8'h01, 8'h00);
        restore();
    endtask

    task automatic t_ext();
        logic [7:0] d;
        pin_in = 8'h01;
        settle();
        bus_read(A_IRQ, d); check("R8 rising edge sets flag", d & 8'h02, 8'h02);
        bus_write(A_IRQ, 8'h00);
        bus_read(A_IRQ, d); check("R9 write 0 clears ext flag", d & 8'h02, 8'h00);
        pin_in = 8'h00;
        settle();
        bus_read(A_IRQ, d); check("R8 falling ignored in rising mode", d & 8'h02, 8'h00);
        bus_write(A_CFG, 8'h01);
        pin_in = 8'h01;
        settle();
        bus_read(A_IRQ, d); check("R8 rising ignored in falling mode", d & 8'h02, 8'h00);
        pin_in = 8'h00;
        settle();
        bus_read(A_IRQ, d); check("R8 falling edge sets flag", d & 8'h02, 8'h02);
        bus_write(A_IRQ, 8'h22);
        check("R10 irq_ext asserted", {7'b0, irq_ext}, 8'h01);
        bus_read(A_IRQ, d); check("R9 write 1 keeps flag", d, 8'h22);
        bus_write(A_IRQ, 8'h20);
        check("R9 irq_ext drops after clear", {7'b0, irq_ext}, 8'h00);
        bus_write(A_IRQ, 8'h03);
        bus_read(A_IRQ, d); check("R9 write 1 never sets", d, 8'h00);
        restore();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_pullup();
        t_change();
        t_ext();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule